// File: doc/BRIEF.md
# Multi-Rate Ping-Pong Parameter Buffer

This block sits between a stream of sensor parameters that arrive at different rates and a downstream engine that consumes them in batches. Each incoming write carries a two-bit kind tag: a per-pulse sample (range and scan angle packed into one word), an attitude sample that arrives at a medium rate, or a position sample that arrives at the slowest rate. Each kind lands in its own region of the bank that is currently filling.

There are two banks. One bank fills while the other is offered to the consumer. The banks trade roles only when three conditions hold together: the fast region of the filling bank is full, that bank has taken at least one position sample, and the consumer has reported that it finished with the bank it holds. After each swap a one-cycle batch-ready pulse is raised, and the per-region counts of the newly readable bank are presented. The consumer then reads words by kind and index. Writes that find their region full are dropped, and a sticky overflow flag is set. Reads beyond the stored count return zero and an error flag.

Top module: `param_pingpong_buf`

## Requirements
- R1: After reset, fill_bank is 0, batch_ready and overflow are 0, and all three batch counts are 0. A read of any kind and index then returns rd_err=1 with rd_data=0.
- R2: Kind 0 is a fast sample, kind 1 is attitude and kind 2 is position. Within one batch, a read of kind k at index i returns the i-th word of kind k written into that batch.
- R3: A swap happens only when the filling bank holds FAST_DEPTH fast samples and at least one position sample. A full fast region with no position sample never swaps. Each swap toggles fill_bank.
- R4: After a swap, no further swap occurs until drain_done has been pulsed. While the consumer is still busy, fill_bank holds its value.
- R5: batch_ready is high for exactly the one cycle after a swap. From that cycle until the next swap, batch_fast_cnt, batch_att_cnt and batch_pos_cnt show the counts of the readable bank.
- R6: A write of kind 3 is discarded. A write to a region that is already full is discarded and sets overflow, which stays high until reset. The contents of the readable bank stay unchanged.
- R7: rd_valid rises one cycle after rd_en. If the index is below the stored count of that kind, rd_data is the stored word. Otherwise, or for kind 3, rd_data is 0 and rd_err is 1.
- R8: A write presented in the same cycle as a swap is stored at index 0 of the new filling bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe |
| wr_kind | input | 2 | Write kind: 0 fast, 1 attitude, 2 position, 3 reserved |
| wr_data | input | WORD_W | Packed parameter word |
| drain_done | input | 1 | Consumer has finished with the readable bank |
| rd_en | input | 1 | Read request |
| rd_kind | input | 2 | Read kind, same encoding as wr_kind |
| rd_idx | input | CNT_W | Index within the region of that kind |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | WORD_W | Read word, or zero on error |
| rd_err | output | 1 | Read was out of range |
| fill_bank | output | 1 | Bank currently filling |
| batch_ready | output | 1 | One-cycle pulse after a swap |
| batch_fast_cnt | output | CNT_W | Fast samples in the readable bank |
| batch_att_cnt | output | CNT_W | Attitude samples in the readable bank |
| batch_pos_cnt | output | CNT_W | Position samples in the readable bank |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The hardest state to reach is a filling bank that is full, already holds a position sample, and still cannot swap because the consumer has not released the other bank. In that state, writes must be dropped and no swap may occur. The directed part of the stimulus completes one batch, withholds drain_done while it fills the second bank completely, and then keeps writing. The random phase then mixes tag weights and drain_done pulses so that swaps, blocked swaps and writes landing in the swap cycle all recur many times.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  typedef enum logic [1:0] {
    KIND_FAST = 2'd0,
    KIND_ATT  = 2'd1,
    KIND_POS  = 2'd2,
    KIND_RSVD = 2'd3
  } kind_e;
  localparam int N_REGION = 3;
endpackage

// File: rtl/ppbuf_bank.sv
module ppbuf_bank #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 38,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  // storage array, no reset: emptiness is tracked by the counters
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem_q[rd_addr];
  end
endmodule

// File: rtl/ppbuf_fill_ctrl.sv
module ppbuf_fill_ctrl
  import ppbuf_pkg::*;
#(
  parameter int FAST_DEPTH = 32,
  parameter int ATT_DEPTH  = 5,
  parameter int POS_DEPTH  = 1,
  parameter int CNT_W      = 6,
  parameter int AW         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [1:0]       wr_kind,
  input  logic             drain_done,
  output logic             wr_en,
  output logic             wr_bank,
  output logic [AW-1:0]    wr_addr,
  output logic             fill_sel,
  output logic             reader_busy,
  output logic             batch_ready,
  output logic [CNT_W-1:0] bcnt_fast,
  output logic [CNT_W-1:0] bcnt_att,
  output logic [CNT_W-1:0] bcnt_pos,
  output logic             overflow
);
  function automatic int unsigned region_depth(int r);
    case (r)
      0:       return FAST_DEPTH;
      1:       return ATT_DEPTH;
      default: return POS_DEPTH;
    endcase
  endfunction

  logic                sel_q, sel_d, busy_q, busy_d, seen_q, seen_d;
  logic                ovf_q, ovf_d, br_q, br_d, swap, drop;
  logic [N_REGION-1:0] hit, room;
  logic [CNT_W-1:0]    cnt_q [N_REGION];
  logic [CNT_W-1:0]    cnt_d [N_REGION];
  logic [CNT_W-1:0]    base_cnt [N_REGION];
  logic [CNT_W-1:0]    bcnt_q [N_REGION];
  logic [CNT_W-1:0]    bcnt_d [N_REGION];

  // swap decision uses registered state only
  assign swap = (cnt_q[0] == CNT_W'(FAST_DEPTH)) && seen_q && !busy_q;

  for (genvar r = 0; r < N_REGION; r++) begin : g_region
    assign base_cnt[r] = swap ? '0 : cnt_q[r];
    assign hit[r]      = wr_valid && (wr_kind == 2'(r));
    assign room[r]     = base_cnt[r] < CNT_W'(region_depth(r));
    assign cnt_d[r]    = base_cnt[r] + ((hit[r] && room[r]) ? CNT_W'(1) : CNT_W'(0));
    assign bcnt_d[r]   = swap ? cnt_q[r] : bcnt_q[r];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[r]  <= '0;
        bcnt_q[r] <= '0;
      end else begin
        cnt_q[r]  <= cnt_d[r];
        bcnt_q[r] <= bcnt_d[r];
      end
    end
  end

  always_comb begin
    wr_en   = |(hit & room);
    drop    = |(hit & ~room);
    wr_bank = sel_q ^ swap;
    case (kind_e'(wr_kind))
      KIND_FAST: wr_addr = AW'(base_cnt[0]);
      KIND_ATT:  wr_addr = AW'(FAST_DEPTH) + AW'(base_cnt[1]);
      KIND_POS:  wr_addr = AW'(FAST_DEPTH + ATT_DEPTH) + AW'(base_cnt[2]);
      default:   wr_addr = '0;
    endcase
    sel_d  = sel_q ^ swap;
    busy_d = swap | (busy_q & ~drain_done);
    seen_d = (seen_q & ~swap) | (hit[2] & room[2]);
    ovf_d  = ovf_q | drop;
    br_d   = swap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      busy_q <= 1'b0;
      seen_q <= 1'b0;
      ovf_q  <= 1'b0;
      br_q   <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      busy_q <= busy_d;
      seen_q <= seen_d;
      ovf_q  <= ovf_d;
      br_q   <= br_d;
    end
  end

  assign fill_sel    = sel_q;
  assign reader_busy = busy_q;
  assign batch_ready = br_q;
  assign overflow    = ovf_q;
  assign bcnt_fast   = bcnt_q[0];
  assign bcnt_att    = bcnt_q[1];
  assign bcnt_pos    = bcnt_q[2];
endmodule

// File: rtl/param_pingpong_buf.sv
module param_pingpong_buf
  import ppbuf_pkg::*;
#(
  parameter int WORD_W     = 64,
  parameter int FAST_DEPTH = 32,
  parameter int ATT_DEPTH  = 5,
  parameter int POS_DEPTH  = 1,
  localparam int CNT_W     = $clog2(FAST_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_kind,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              drain_done,
  input  logic              rd_en,
  input  logic [1:0]        rd_kind,
  input  logic [CNT_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_err,
  output logic              fill_bank,
  output logic              batch_ready,
  output logic [CNT_W-1:0]  batch_fast_cnt,
  output logic [CNT_W-1:0]  batch_att_cnt,
  output logic [CNT_W-1:0]  batch_pos_cnt,
  output logic              overflow
);
  localparam int TOTAL = FAST_DEPTH + ATT_DEPTH + POS_DEPTH;
  localparam int AW    = $clog2(TOTAL);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              wr_en, wr_bank, rd_busy, in_range, rd_sel;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic              rd_valid_q, rd_valid_d, rd_err_q, rd_err_d, rd_sel_q, rd_sel_d;
  logic [WORD_W-1:0] bank_rdata [2];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ppbuf_fill_ctrl #(
    .FAST_DEPTH(FAST_DEPTH), .ATT_DEPTH(ATT_DEPTH), .POS_DEPTH(POS_DEPTH),
    .CNT_W(CNT_W), .AW(AW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .wr_valid(wr_valid), .wr_kind(wr_kind),
    .drain_done(drain_done), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .fill_sel(fill_bank), .reader_busy(rd_busy), .batch_ready(batch_ready),
    .bcnt_fast(batch_fast_cnt), .bcnt_att(batch_att_cnt), .bcnt_pos(batch_pos_cnt),
    .overflow(overflow)
  );

  always_comb begin
    case (kind_e'(rd_kind))
      KIND_FAST: begin
        in_range = rd_idx < batch_fast_cnt;
        rd_addr  = AW'(rd_idx);
      end
      KIND_ATT: begin
        in_range = rd_idx < batch_att_cnt;
        rd_addr  = AW'(FAST_DEPTH) + AW'(rd_idx);
      end
      KIND_POS: begin
        in_range = rd_idx < batch_pos_cnt;
        rd_addr  = AW'(FAST_DEPTH + ATT_DEPTH) + AW'(rd_idx);
      end
      default: begin
        in_range = 1'b0;
        rd_addr  = '0;
      end
    endcase
    rd_valid_d = rd_en;
    rd_err_d   = rd_en && !in_range;
    rd_sel_d   = rd_en ? ~fill_bank : rd_sel_q;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ppbuf_bank #(.WORD_W(WORD_W), .DEPTH(TOTAL), .AW(AW)) u_bank (
      .clk(clk),
      .wr_en(wr_en && (wr_bank == 1'(b))),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_en(rd_en && in_range && (fill_bank != 1'(b))),
      .rd_addr(rd_addr),
      .rd_data(bank_rdata[b])
    );
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid_q <= 1'b0;
      rd_err_q   <= 1'b0;
      rd_sel_q   <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_err_q   <= rd_err_d;
      rd_sel_q   <= rd_sel_d;
    end
  end

  assign rd_sel   = rd_sel_q;
  assign rd_valid = rd_valid_q;
  assign rd_err   = rd_err_q;
  assign rd_data  = (rd_valid_q && !rd_err_q) ? bank_rdata[rd_sel] : '0;
endmodule

// File: rtl/ppbuf_checker.sv
module ppbuf_checker #(
  parameter int WORD_W     = 64,
  parameter int FAST_DEPTH = 32,
  parameter int CNT_W      = 6
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              rd_err,
  input logic [WORD_W-1:0] rd_data,
  input logic              fill_bank,
  input logic              batch_ready,
  input logic [CNT_W-1:0]  batch_fast_cnt,
  input logic [CNT_W-1:0]  batch_pos_cnt,
  input logic              overflow,
  input logic              rd_busy
);
  AST_SWAP_NEEDS_SLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    batch_ready |-> (batch_fast_cnt == CNT_W'(FAST_DEPTH)) && (batch_pos_cnt != '0)); // R3
  AST_BANK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_int_n)
    batch_ready |-> fill_bank != $past(fill_bank)); // R3
  AST_BUSY_HOLDS_BANK: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_busy |=> $stable(fill_bank)); // R4
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    batch_ready |=> !batch_ready); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    overflow |=> overflow); // R6
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_err |-> rd_valid && (rd_data == '0)); // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_en |=> rd_valid); // R7
endmodule

bind param_pingpong_buf ppbuf_checker #(
  .WORD_W(WORD_W), .FAST_DEPTH(FAST_DEPTH), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_int_n(rst_int_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_err(rd_err), .rd_data(rd_data), .fill_bank(fill_bank),
  .batch_ready(batch_ready), .batch_fast_cnt(batch_fast_cnt),
  .batch_pos_cnt(batch_pos_cnt), .overflow(overflow), .rd_busy(rd_busy)
);

// File: tb/param_pingpong_buf_tb.sv
module param_pingpong_buf_tb_top;
  localparam int F = 32, A = 5, P = 1, TOT = F + A + P, CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, drain_done = 1'b0, rd_en = 1'b0;
  logic [1:0]    wr_kind = '0, rd_kind = '0;
  logic [63:0]   wr_data = '0;
  logic [CW-1:0] rd_idx = '0;
  logic          rd_valid, rd_err, fill_bank, batch_ready, overflow;
  logic [63:0]   rd_data;
  logic [CW-1:0] batch_fast_cnt, batch_att_cnt, batch_pos_cnt;

  int  checks = 0, fails = 0;
  bit  done = 0;

  // reference state
  logic [63:0] m_fill [TOT];
  logic [63:0] r_mem  [TOT];
  int          m_cnt [3];
  int          r_cnt [3];
  bit          m_seen, m_busy, m_sel, m_br, m_ovf;

  always #4ns clk = ~clk;

  param_pingpong_buf dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_kind(wr_kind),
    .wr_data(wr_data), .drain_done(drain_done), .rd_en(rd_en), .rd_kind(rd_kind),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .fill_bank(fill_bank), .batch_ready(batch_ready), .batch_fast_cnt(batch_fast_cnt),
    .batch_att_cnt(batch_att_cnt), .batch_pos_cnt(batch_pos_cnt), .overflow(overflow)
  );

  function automatic int dep(int k);
    return (k == 0) ? F : (k == 1) ? A : P;
  endfunction
  function automatic int base(int k);
    return (k == 0) ? 0 : (k == 1) ? F : F + A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin m_cnt[k] = 0; r_cnt[k] = 0; end
    m_seen = 0; m_busy = 0; m_sel = 0; m_br = 0; m_ovf = 0;
  endtask

  task automatic model_edge(input bit v, input int k, input logic [63:0] d, input bit dr);
    bit sw;
    sw = (m_cnt[0] == F) && m_seen && !m_busy;
    m_br = sw;
    if (sw) begin
      r_mem = m_fill;
      for (int j = 0; j < 3; j++) begin r_cnt[j] = m_cnt[j]; m_cnt[j] = 0; end
      m_seen = 0; m_busy = 1; m_sel = !m_sel;
    end else if (dr) m_busy = 0;
    if (v && k != 3) begin
      if (m_cnt[k] < dep(k)) begin
        m_fill[base(k) + m_cnt[k]] = d;
        m_cnt[k]++;
        if (k == 2) m_seen = 1;
      end else m_ovf = 1;
    end
  endtask

  task automatic check_state(input string tag);
    chk(fill_bank == m_sel, {tag, " R3 fill_bank"}, 64'(fill_bank), 64'(m_sel));
    chk(batch_ready == m_br, {tag, " R5 batch_ready"}, 64'(batch_ready), 64'(m_br));
    chk(overflow == m_ovf, {tag, " R6 overflow"}, 64'(overflow), 64'(m_ovf));
    if (m_br) begin
      chk(int'(batch_fast_cnt) == r_cnt[0], "R5 fast count", 64'(batch_fast_cnt), 64'(r_cnt[0]));
      chk(int'(batch_att_cnt) == r_cnt[1], "R5 att count", 64'(batch_att_cnt), 64'(r_cnt[1]));
      chk(int'(batch_pos_cnt) == r_cnt[2], "R5 pos count", 64'(batch_pos_cnt), 64'(r_cnt[2]));
    end
  endtask

  // one cycle of traffic: drive after a falling edge, check at the next
  task automatic step(input bit v, input int k, input logic [63:0] d, input bit dr, input string tag);
    wr_valid = v; wr_kind = 2'(k); wr_data = d; drain_done = dr; rd_en = 0;
    @(posedge clk);
    model_edge(v, k, d, dr);
    @(negedge clk);
    wr_valid = 0; drain_done = 0;
    check_state(tag);
  endtask

  task automatic rd(input int k, input int idx, input string tag);
    logic [63:0] exp_d;
    bit          exp_e;
    exp_e = !(k < 3 && idx < r_cnt[k]);
    exp_d = exp_e ? 64'd0 : r_mem[base(k) + idx];
    rd_en = 1; rd_kind = 2'(k); rd_idx = CW'(idx); wr_valid = 0; drain_done = 0;
    @(posedge clk);
    model_edge(0, 0, 64'd0, 0);
    @(negedge clk);
    rd_en = 0;
    chk(rd_valid == 1'b1, {tag, " R7 rd_valid"}, 64'(rd_valid), 64'd1);
    chk(rd_err == exp_e, {tag, " R7 rd_err"}, 64'(rd_err), 64'(exp_e));
    chk(rd_data == exp_d, {tag, " R2 rd_data"}, rd_data, exp_d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_valid = 0; drain_done = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    model_reset();
    chk(fill_bank == 1'b0, "R1 fill_bank", 64'(fill_bank), 64'd0);
    chk(batch_ready == 1'b0, "R1 batch_ready", 64'(batch_ready), 64'd0);
    chk(overflow == 1'b0, "R1 overflow", 64'(overflow), 64'd0);
    chk(batch_fast_cnt == '0 && batch_att_cnt == '0 && batch_pos_cnt == '0, "R1 counts",
        64'({batch_fast_cnt, batch_att_cnt, batch_pos_cnt}), 64'd0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    model_reset();
    do_reset();
    rd(0, 0, "R1 empty read");

    // first batch: fast region full, no position yet
    for (int i = 0; i < F; i++) step(1, 0, rnd64(), 0, "fill1");
    for (int i = 0; i < A; i++) step(1, 1, rnd64(), 0, "fill1");
    repeat (3) step(0, 0, 64'd0, 0, "R3 hold");
    chk(fill_bank == 1'b0, "R3 no swap without position", 64'(fill_bank), 64'd0);
    step(1, 0, 64'hDEAD, 0, "R6 full drop");
    chk(overflow == 1'b1, "R6 overflow set", 64'(overflow), 64'd1);
    step(1, 3, 64'hBEEF, 0, "R6 reserved");
    step(1, 2, 64'h1234_5678_9ABC_DEF0, 0, "pos");
    // swap happens on this edge; the write goes to the new bank
    step(1, 0, 64'hAAAA_5555_AAAA_5555, 0, "R8 swap write");
    chk(batch_ready == 1'b1, "R5 pulse after swap", 64'(batch_ready), 64'd1);
    step(0, 0, 64'd0, 0, "R5 pulse end");

    rd(0, 0, "R2 first"); rd(0, F - 1, "R2 last"); rd(0, F, "R7 fast over");
    rd(1, A - 1, "R2 att last"); rd(1, A, "R7 att over");
    rd(2, 0, "R2 pos"); rd(2, 1, "R7 pos over"); rd(3, 0, "R7 kind3");

    // second batch fills while the consumer still holds the first
    for (int i = 1; i < F; i++) step(1, 0, rnd64(), 0, "fill2");
    step(1, 2, rnd64(), 0, "fill2 pos");
    repeat (4) step(0, 0, 64'd0, 0, "R4 blocked");
    chk(fill_bank == 1'b1, "R4 no swap while busy", 64'(fill_bank), 64'd1);
    step(1, 0, 64'hFFFF, 0, "R6 blocked drop");
    rd(0, F - 1, "R6 readable intact");
    step(0, 0, 64'd0, 1, "R4 drain");
    step(0, 0, 64'd0, 0, "R4 swap");
    chk(fill_bank == 1'b0, "R4 swap after drain", 64'(fill_bank), 64'd0);
    rd(0, 0, "R8 swap word at index 0");
    chk(rd_data == 64'hAAAA_5555_AAAA_5555, "R8 swap word", rd_data, 64'hAAAA_5555_AAAA_5555);

    // random traffic from a clean reset
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int r, k;
      bit v, dr;
      r  = int'($urandom % 16);
      k  = (r < 12) ? 0 : (r < 14) ? 1 : (r < 15) ? 2 : 3;
      v  = ($urandom % 4) != 0;
      dr = m_busy && (($urandom % 24) == 0);
      if (m_busy && (($urandom % 5) == 0))
        rd(int'($urandom % 4), int'($urandom % 40), "rand read");
      else
        step(v, k, rnd64(), dr, "rand");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule